// File: doc/BRIEF.md
# Accumulator Microoperation Datapath

This block holds a 16-bit accumulator and the bit-sliced arithmetic and logic network that feeds it. Each clock edge it either clears the register, increments it, loads one of seven computed results into it, or leaves it unchanged. All of its control terms are derived inside the block from one-hot decoded opcode lines, one-hot timing lines, the indirect-address bit and the low twelve instruction bits. The result options are: AND, add, or transfer with the data register; an 8-bit load from the input register; complement; and one-position shifts in either direction that fill the vacated end with the extend bit.

The add stage's carry-out is presented combinationally as the new extend value. A write strobe for the extend bit is raised only while the add is selected. The surrounding sequencer owns the extend flip-flop, the sequence counter and memory. This block only consumes their values.

Top module: `acc_datapath`

## Requirements
- R1: While rst_ni is low the accumulator reads 0x0000, and it clears asynchronously, without waiting for a clock edge.
- R2: With d_i[0] and t_i[5] high, the next edge loads ac_o AND dr_i.
- R3: With d_i[1] and t_i[5] high, the next edge loads (ac_o + dr_i) mod 2^16. In that cycle e_we_o is 1 and e_o equals the carry out of bit 15. In every cycle without that control, e_we_o is 0.
- R4: With d_i[2] and t_i[5] high, the next edge loads dr_i unchanged.
- R5: The input control is d_i[7] & ind_i & t_i[3]. With it and ir_i[11] high, the next edge loads inpr_i into bits 7..0 and clears bits 15..8.
- R6: The register control is d_i[7] & ~ind_i & t_i[3]. With it and ir_i[9] high, the next edge loads ~ac_o.
- R7: With the register control and ir_i[7] high, the next edge shifts right: bit i takes bit i+1, and bit 15 takes e_i.
- R8: With the register control and ir_i[6] high, the next edge shifts left: bit i takes bit i-1, and bit 0 takes e_i.
- R9: With the register control and ir_i[11] high, the next edge clears the accumulator to 0x0000.
- R10: With the register control and ir_i[5] high, the next edge loads ac_o + 1, wrapping 0xFFFF to 0x0000.
- R11: When terms overlap, clear wins over increment, and increment wins over every loaded result.
- R12: When no control term is active, the accumulator keeps its value. This includes the right opcode at the wrong timing step, and the input control with an instruction bit other than 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| d_i | input | 8 | One-hot decoded opcode lines |
| t_i | input | 8 | One-hot timing step lines |
| ind_i | input | 1 | Indirect-address bit |
| ir_i | input | 12 | Low instruction-register bits |
| dr_i | input | 16 | Data register value |
| inpr_i | input | 8 | Input register value |
| e_i | input | 1 | Current extend bit |
| ac_o | output | 16 | Accumulator value |
| e_o | output | 1 | Carry out of the add, new extend value |
| e_we_o | output | 1 | Extend write strobe, high only during the add |

## Verification
Clear, increment and complement share one decoded term. Setting ir_i[11] and ir_i[5] together, or ir_i[9] and ir_i[5] together, therefore lands two functions in the same cycle. The bench drives both pairs from a preloaded value. It judges the outcome against the priority rule: 0x1234 must become 0x0000, and 0x0010 must become 0x0011 rather than its complement. Near misses are also driven and must leave the register unchanged: the correct opcode at the wrong timing step, and the input control paired with an unused bit.

// File: rtl/acc_pkg.sv
package acc_pkg;
  // decoded opcode line indices
  localparam int unsigned OP_AND = 0;
  localparam int unsigned OP_ADD = 1;
  localparam int unsigned OP_LDA = 2;
  localparam int unsigned OP_REG = 7;
  // timing step indices
  localparam int unsigned T_EXEC = 5;
  localparam int unsigned T_REG  = 3;
  // instruction bit selectors
  localparam int unsigned IR_CLR = 11;
  localparam int unsigned IR_INP = 11;
  localparam int unsigned IR_CMP = 9;
  localparam int unsigned IR_SHR = 7;
  localparam int unsigned IR_SHL = 6;
  localparam int unsigned IR_INC = 5;

  typedef struct packed {
    logic and_dr;
    logic add_dr;
    logic ld_dr;
    logic ld_in;
    logic cmp;
    logic shr;
    logic shl;
  } path_ops_t;

  typedef struct packed {
    path_ops_t path;
    logic      clr;
    logic      inc;
  } acc_ctl_t;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int unsigned NUM_D = 8,
  parameter int unsigned NUM_T = 8,
  parameter int unsigned IRW   = 12
) (
  input  logic [NUM_D-1:0] d_i,
  input  logic [NUM_T-1:0] t_i,
  input  logic             ind_i,
  input  logic [IRW-1:0]   ir_i,
  output acc_ctl_t         ctl_o,
  output logic             ld_o
);
  logic reg_ref;
  logic io_ref;
  logic exec;

  assign reg_ref = d_i[OP_REG] & ~ind_i & t_i[T_REG];
  assign io_ref  = d_i[OP_REG] &  ind_i & t_i[T_REG];
  assign exec    = t_i[T_EXEC];

  always_comb begin
    ctl_o.path.and_dr = d_i[OP_AND] & exec;
    ctl_o.path.add_dr = d_i[OP_ADD] & exec;
    ctl_o.path.ld_dr  = d_i[OP_LDA] & exec;
    ctl_o.path.ld_in  = io_ref & ir_i[IR_INP];
    ctl_o.path.cmp    = reg_ref & ir_i[IR_CMP];
    ctl_o.path.shr    = reg_ref & ir_i[IR_SHR];
    ctl_o.path.shl    = reg_ref & ir_i[IR_SHL];
    ctl_o.clr         = reg_ref & ir_i[IR_CLR];
    ctl_o.inc         = reg_ref & ir_i[IR_INC];
  end

  assign ld_o = |ctl_o.path;
endmodule

// File: rtl/acc_bit_stage.sv
module acc_bit_stage
  import acc_pkg::*;
(
  input  path_ops_t ops_i,
  input  logic      ac_i,
  input  logic      ac_up_i,  // bit i+1 (or extend at the top)
  input  logic      ac_dn_i,  // bit i-1 (or extend at the bottom)
  input  logic      dr_i,
  input  logic      in_i,
  input  logic      c_i,
  output logic      d_o,
  output logic      c_o
);
  logic sum;

  assign sum = ac_i ^ dr_i ^ c_i;
  assign c_o = (ac_i & dr_i) | (c_i & (ac_i ^ dr_i));

  assign d_o = (ops_i.and_dr & ac_i & dr_i)
             | (ops_i.add_dr & sum)
             | (ops_i.ld_dr  & dr_i)
             | (ops_i.ld_in  & in_i)
             | (ops_i.cmp    & ~ac_i)
             | (ops_i.shr    & ac_up_i)
             | (ops_i.shl    & ac_dn_i);
endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic          ld_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= q_o + 1'b1;
    else if (ld_i)  q_o <= d_i;
  end

  // R9 R11
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> q_o == '0);

  // R10 R11
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> q_o == DW'($past(q_o) + 1'b1));

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i && !ld_i) |=> $stable(q_o));
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned IW    = 8,
  parameter int unsigned NUM_D = 8,
  parameter int unsigned NUM_T = 8,
  parameter int unsigned IRW   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_D-1:0] d_i,
  input  logic [NUM_T-1:0] t_i,
  input  logic             ind_i,
  input  logic [IRW-1:0]   ir_i,
  input  logic [DW-1:0]    dr_i,
  input  logic [IW-1:0]    inpr_i,
  input  logic             e_i,
  output logic [DW-1:0]    ac_o,
  output logic             e_o,
  output logic             e_we_o
);
  acc_ctl_t      ctl;
  logic          ld;
  logic [DW-1:0] nxt;
  logic [DW:0]   carry;
  logic [DW+1:0] ac_ext;  // extend bit at both ends for shifts

  acc_ctrl #(.NUM_D(NUM_D), .NUM_T(NUM_T), .IRW(IRW)) u_ctrl (
    .d_i   (d_i),
    .t_i   (t_i),
    .ind_i (ind_i),
    .ir_i  (ir_i),
    .ctl_o (ctl),
    .ld_o  (ld)
  );

  assign ac_ext   = {e_i, ac_o, e_i};
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < DW; i++) begin : g_stage
    logic in_bit;
    if (i < IW) begin : g_in
      assign in_bit = inpr_i[i];
    end else begin : g_no_in
      assign in_bit = 1'b0;
    end
    acc_bit_stage u_stage (
      .ops_i   (ctl.path),
      .ac_i    (ac_o[i]),
      .ac_up_i (ac_ext[i+2]),
      .ac_dn_i (ac_ext[i]),
      .dr_i    (dr_i[i]),
      .in_i    (in_bit),
      .c_i     (carry[i]),
      .d_o     (nxt[i]),
      .c_o     (carry[i+1])
    );
  end

  acc_reg #(.DW(DW)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctl.clr),
    .inc_i  (ctl.inc),
    .ld_i   (ld),
    .d_i    (nxt),
    .q_o    (ac_o)
  );

  assign e_o    = carry[DW];
  assign e_we_o = ctl.path.add_dr;

  // R3
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl.path.add_dr && !ctl.clr && !ctl.inc)
      |=> {$past(e_o), ac_o} == ({1'b0, $past(ac_o)} + {1'b0, $past(dr_i)}));

  // R7
  shr_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl.path.shr && !ctl.clr && !ctl.inc && $onehot(ctl.path))
      |=> ac_o == {$past(e_i), $past(ac_o[DW-1:1])});

  // R8
  shl_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl.path.shl && !ctl.clr && !ctl.inc && $onehot(ctl.path))
      |=> ac_o == {$past(ac_o[DW-2:0]), $past(e_i)});

  // R5
  inp_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl.path.ld_in && !ctl.clr && !ctl.inc && $onehot(ctl.path))
      |=> ac_o == {{(DW-IW){1'b0}}, $past(inpr_i)});
endmodule

// File: tb/acc_datapath_test.sv
`timescale 1ns/1ps
module acc_datapath_test;
  typedef struct packed {
    logic [2:0]  d_sel;
    logic [2:0]  t_sel;
    logic        ind;
    logic [11:0] ir;
    logic [15:0] init;
    logic [15:0] dr;
    logic [7:0]  inpr;
    logic        e;
    logic [15:0] exp_ac;
    logic        exp_e;
    logic        exp_we;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd5, 1'b0, 12'h000, 16'hF0F0, 16'h3C3C, 8'h00, 1'b0, 16'h3030, 1'b0, 1'b0, 4'd2},  // R2
    '{3'd1, 3'd5, 1'b0, 12'h000, 16'h1234, 16'h1111, 8'h00, 1'b0, 16'h2345, 1'b0, 1'b1, 4'd3},  // R3
    '{3'd1, 3'd5, 1'b0, 12'h000, 16'hFFFF, 16'h0002, 8'h00, 1'b0, 16'h0001, 1'b1, 1'b1, 4'd3},  // R3 carry
    '{3'd2, 3'd5, 1'b0, 12'h000, 16'hAAAA, 16'h5A5A, 8'h00, 1'b0, 16'h5A5A, 1'b0, 1'b0, 4'd4},  // R4
    '{3'd7, 3'd3, 1'b1, 12'h800, 16'hBEEF, 16'h0000, 8'h7E, 1'b0, 16'h007E, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd7, 3'd3, 1'b0, 12'h200, 16'h00FF, 16'h0000, 8'h00, 1'b0, 16'hFF00, 1'b0, 1'b0, 4'd6},  // R6
    '{3'd7, 3'd3, 1'b0, 12'h080, 16'h8002, 16'h0000, 8'h00, 1'b1, 16'hC001, 1'b0, 1'b0, 4'd7},  // R7
    '{3'd7, 3'd3, 1'b0, 12'h040, 16'h8002, 16'h0000, 8'h00, 1'b1, 16'h0005, 1'b0, 1'b0, 4'd8},  // R8
    '{3'd7, 3'd3, 1'b0, 12'h080, 16'h0001, 16'h0000, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7 e=0
    '{3'd7, 3'd3, 1'b0, 12'h800, 16'h1234, 16'h0000, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9
    '{3'd7, 3'd3, 1'b0, 12'h020, 16'hFFFF, 16'h0000, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd10}, // R10 wrap
    '{3'd7, 3'd3, 1'b0, 12'h020, 16'h00FF, 16'h0000, 8'h00, 1'b0, 16'h0100, 1'b0, 1'b0, 4'd10}, // R10
    '{3'd7, 3'd3, 1'b0, 12'h820, 16'h1234, 16'h0000, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd11}, // R11 clr+inc
    '{3'd7, 3'd3, 1'b0, 12'h220, 16'h0010, 16'h0000, 8'h00, 1'b0, 16'h0011, 1'b0, 1'b0, 4'd11}, // R11 inc+cmp
    '{3'd7, 3'd4, 1'b0, 12'h200, 16'h4321, 16'h0000, 8'h00, 1'b0, 16'h4321, 1'b0, 1'b0, 4'd12}, // R12 wrong step
    '{3'd7, 3'd3, 1'b1, 12'h200, 16'h4321, 16'h0000, 8'h55, 1'b0, 16'h4321, 1'b0, 1'b0, 4'd12}, // R12 io other bit
    '{3'd0, 3'd4, 1'b0, 12'h000, 16'h5555, 16'h0000, 8'h00, 1'b0, 16'h5555, 1'b0, 1'b0, 4'd12}  // R12 and at T4
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  d_i = '0;
  logic [7:0]  t_i = '0;
  logic        ind_i = 1'b0;
  logic [11:0] ir_i = '0;
  logic [15:0] dr_i = '0;
  logic [7:0]  inpr_i = '0;
  logic        e_i = 1'b0;
  logic [15:0] ac_o;
  logic        e_o;
  logic        e_we_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  acc_datapath uut (
    .clk_i (clk), .rst_ni (rst_ni), .d_i (d_i), .t_i (t_i), .ind_i (ind_i),
    .ir_i (ir_i), .dr_i (dr_i), .inpr_i (inpr_i), .e_i (e_i),
    .ac_o (ac_o), .e_o (e_o), .e_we_o (e_we_o)
  );

  task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp,
                       input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    d_i = '0; t_i = '0; ind_i = 1'b0; ir_i = '0; dr_i = '0; inpr_i = '0; e_i = 1'b0;
  endtask

  task automatic preload(input logic [15:0] v);
    @(posedge clk); #1;
    idle();
    d_i = 8'b1 << 2; t_i = 8'b1 << 5; dr_i = v;
    @(posedge clk); #1;
    idle();
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    check(1, ac_o, 16'h0000, "reset value");                 // R1
    rst_ni = 1'b1;
    @(posedge clk); #1;
    check(3, {15'd0, e_we_o}, 16'h0001 & 16'h0000, "idle strobe"); // R3

    for (int k = 0; k < NV; k++) begin
      vec_t v = VECS[k];
      preload(v.init);
      d_i = 8'b1 << v.d_sel; t_i = 8'b1 << v.t_sel; ind_i = v.ind;
      ir_i = v.ir; dr_i = v.dr; inpr_i = v.inpr; e_i = v.e;
      @(negedge clk);
      check(int'(v.req), {15'd0, e_we_o}, {15'd0, v.exp_we}, "extend strobe");
      if (v.exp_we) check(int'(v.req), {15'd0, e_o}, {15'd0, v.exp_e}, "carry out");
      @(posedge clk); #1;
      idle();
      check(int'(v.req), ac_o, v.exp_ac, "accumulator");
    end

    // R12: hold over several idle cycles
    preload(16'h1357);
    for (int n = 0; n < 3; n++) begin
      @(posedge clk); #1;
      check(12, ac_o, 16'h1357, "idle hold");
    end

    // R1: asynchronous clear mid-cycle
    preload(16'hABCD);
    #2 rst_ni = 1'b0;
    #1 check(1, ac_o, 16'h0000, "async reset");
    @(posedge clk); #1;
    rst_ni = 1'b1;
    check(1, ac_o, 16'h0000, "after reset");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule